// File: doc/BRIEF.md
# Supply Supervisor with Heartbeat Watchdog

This block produces one active-low reset for a system. It combines two sources. The first is a supply monitor. While the external comparator reports a bad supply, the reset stays asserted. Once the supply turns good and has stayed good for a programmable number of cycles, the reset is released.

The second source is a watchdog on a heartbeat strobe from the supervised logic. Each timeout period opens with a short window in which heartbeats are not accepted. A heartbeat that arrives after this window clears the watchdog. The block then waits through a recharge phase before it starts a new period. If a period ends with no accepted heartbeat, the block asserts reset for a hold time and then starts a fresh period.

An active-low inhibit input takes the watchdog out of the path. While inhibit is low, the reset follows the supply monitor alone. All durations are counted in clock cycles. The hold time and the ignore window are derived from the timeout length.

Top module: `sup_wdog`

## Requirements
- R1: When `supply_ok` is low, `rst_n_o` is low in that same cycle, whatever state the watchdog is in.
- R2: `rst_n_o` goes high only after `supply_ok` has been high for `REL_CYC` consecutive clocked cycles. Any drop of `supply_ok` restarts this count from zero.
- R3: An accepted heartbeat in a timeout period starts a recharge phase of `RECH_CYC` cycles. `rst_n_o` stays high during the recharge phase, and a new timeout period starts after it.
- R4: If no heartbeat is accepted within the `TWD` cycles of a period, `rst_n_o` is low for `max(1, TWD/9)` cycles. A new timeout period then starts.
- R5: Heartbeats are not accepted in the first `max(1, TWD/10)` cycles of a period, counted from its first cycle. They are also not accepted during the recharge phase.
- R6: Only a rising edge of `beat` counts as a heartbeat. A strobe held high for many cycles counts once.
- R7: While `inhibit_n` is low and the release delay has completed, `rst_n_o` equals `supply_ok` and does not depend on `beat`.
- R8: When `inhibit_n` returns high, supervision resumes with a new timeout period that starts in the next cycle.
- R9: A synchronous `rst` returns the block to waiting for supply, with `rst_n_o` low and the release count cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| supply_ok | input | 1 | Synchronous supply-good flag from the comparator |
| inhibit_n | input | 1 | Active-low watchdog inhibit |
| beat | input | 1 | Heartbeat strobe from the supervised logic |
| rst_n_o | output | 1 | Active-low system reset |

## Verification
The assertions assume that `supply_ok`, `inhibit_n` and `beat` are already synchronous to `clk` and change only between edges. They also assume `rst` is held for at least one edge before any of them is evaluated. The bench drives every input on the falling edge from a single procedural thread, so these conditions hold. The hold-length and release-count properties also assume that `supply_ok` is the only way the supply path can pull the output low. The stimulus respects this, because it never asserts `rst` while reading a hold interval.

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int TWD      = 90,
  parameter int REL_CYC  = 20,
  parameter int RECH_CYC = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic inhibit_n,
  input  logic beat,
  output logic rst_n_o
);
  localparam int HOLD_CYC = (TWD / 9 < 1) ? 1 : TWD / 9;
  localparam int IGN_CYC  = (TWD / 10 < 1) ? 1 : TWD / 10;
  localparam int MAX_A    = (TWD > REL_CYC) ? TWD : REL_CYC;
  localparam int MAX_C    = (MAX_A > RECH_CYC) ? MAX_A : RECH_CYC;
  localparam int CW       = $clog2(MAX_C + 1);

  typedef enum logic [2:0] {S_WAIT, S_RUN, S_RECH, S_HOLD, S_INH} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        beat_q;
  logic        kick;

  assign kick    = beat & ~beat_q;
  assign rst_n_o = supply_ok & (st == S_RUN || st == S_RECH || st == S_INH);

  always_ff @(posedge clk) beat_q <= beat;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok) begin
      st  <= S_WAIT;
      cnt <= '0;
    end else if (st != S_WAIT && st != S_INH && !inhibit_n) begin
      st  <= S_INH;
      cnt <= '0;
    end else begin
      case (st)
        S_WAIT:
          if (cnt == CW'(REL_CYC - 1)) begin
            st  <= inhibit_n ? S_RUN : S_INH;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_RUN:
          if (kick && cnt >= CW'(IGN_CYC)) begin
            st  <= S_RECH;
            cnt <= '0;
          end else if (cnt == CW'(TWD - 1)) begin
            st  <= S_HOLD;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_RECH:
          if (cnt == CW'(RECH_CYC - 1)) begin
            st  <= S_RUN;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_HOLD:
          if (cnt == CW'(HOLD_CYC - 1)) begin
            st  <= S_RUN;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_INH:
          if (inhibit_n) begin
            st  <= S_RUN;
            cnt <= '0;
          end
        default: begin
          st  <= S_WAIT;
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

module sup_wdog_chk #(
  parameter int REL_CYC  = 20,
  parameter int HOLD_CYC = 10
) (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic inhibit_n,
  input logic rst_n_o
);
  logic started;
  int   ok_run;
  int   low_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      started <= 1'b1;
      ok_run  <= 0;
      low_run <= 0;
    end else begin
      ok_run  <= supply_ok ? ((ok_run < REL_CYC + 2) ? ok_run + 1 : ok_run) : 0;
      low_run <= (supply_ok && !rst_n_o && ok_run >= REL_CYC) ? low_run + 1 : 0;
    end
  end

  a_r1_supply_drop: assert property (@(posedge clk) disable iff (rst || !started)
    !supply_ok |=> !supply_ok || !rst_n_o);

  a_r2_release_wait: assert property (@(posedge clk) disable iff (rst || !started)
    rst_n_o |-> ok_run >= REL_CYC);

  a_r4_hold_len: assert property (@(posedge clk) disable iff (rst || !started)
    low_run <= HOLD_CYC);

  a_r7_inhibit_follow: assert property (@(posedge clk) disable iff (rst || !started)
    (!inhibit_n && rst_n_o && supply_ok) |=> (!supply_ok || rst_n_o));
endmodule

bind sup_wdog sup_wdog_chk #(.REL_CYC(REL_CYC), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .inhibit_n(inhibit_n), .rst_n_o(rst_n_o)
);

// File: tb/test_sup_wdog.sv
module test_sup_wdog;
  localparam int TWD  = 90;
  localparam int REL  = 20;
  localparam int RECH = 5;
  localparam int HOLD = 10;
  localparam int IGN  = 9;

  logic clk = 1'b0;
  logic rst = 1'b1, supply_ok = 1'b0, inhibit_n = 1'b1, beat = 1'b0;
  logic rst_n_o;
  int   n_vec = 0, n_bad = 0, ncyc = 0;
  string req = "R9";

  int   phase = 0;
  int   el = 0;
  logic prevb = 1'b0;

  always #10 clk = ~clk;

  sup_wdog #(.TWD(TWD), .REL_CYC(REL), .RECH_CYC(RECH)) i_sup_wdog (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .inhibit_n(inhibit_n),
    .beat(beat), .rst_n_o(rst_n_o)
  );

  function automatic logic expect_out();
    return supply_ok && (phase == 1 || phase == 2 || phase == 4);
  endfunction

  task automatic model_step();
    logic edge_seen;
    edge_seen = beat && !prevb;
    prevb = beat;
    if (rst || !supply_ok) begin
      phase = 0; el = 0;
    end else if ((phase == 1 || phase == 2 || phase == 3) && !inhibit_n) begin
      phase = 4; el = 0;
    end else if (phase == 0) begin
      if (el == REL - 1) begin phase = inhibit_n ? 1 : 4; el = 0; end
      else el++;
    end else if (phase == 1) begin
      if (edge_seen && el >= IGN) begin phase = 2; el = 0; end
      else if (el == TWD - 1) begin phase = 3; el = 0; end
      else el++;
    end else if (phase == 2) begin
      if (el == RECH - 1) begin phase = 1; el = 0; end else el++;
    end else if (phase == 3) begin
      if (el == HOLD - 1) begin phase = 1; el = 0; end else el++;
    end else if (inhibit_n) begin
      phase = 1; el = 0;
    end
  endtask

  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      #1;
      n_vec++;
      if (rst_n_o !== expect_out()) begin
        n_bad++;
        $display("FAIL %s: rst_n_o=%b expected=%b at cycle %0d", req, rst_n_o, expect_out(), ncyc);
      end
      @(posedge clk);
      model_step();
      ncyc++;
      @(negedge clk);
    end
  endtask

  task automatic pulse();
    beat = 1'b1; cyc(1); beat = 1'b0;
  endtask

  initial begin
    #100000000;
    n_bad++;
    $display("FAIL watchdog: run hung");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    req = "R9"; supply_ok = 1'b1; cyc(3);
    rst = 1'b0;
    req = "R2"; cyc(10); supply_ok = 1'b0; cyc(2); supply_ok = 1'b1; cyc(REL + 5);
    req = "R3";
    for (int j = 0; j < 4; j++) begin cyc(30); pulse(); end
    cyc(20);
    req = "R4"; cyc(TWD + HOLD + 20);
    req = "R5";
    while (phase != 3) cyc(1);
    while (phase == 3) cyc(1);
    cyc(3); pulse(); cyc(TWD);
    while (phase != 1) cyc(1);
    cyc(IGN - 1); pulse(); cyc(4);
    while (phase != 1) cyc(1);
    cyc(IGN); pulse(); cyc(1); pulse(); cyc(2); pulse(); cyc(TWD + HOLD);
    req = "R6"; beat = 1'b1; cyc(2 * TWD); beat = 1'b0; cyc(5);
    req = "R7"; inhibit_n = 1'b0; cyc(3 * TWD);
    for (int j = 0; j < 10; j++) pulse();
    while (phase != 3) begin inhibit_n = 1'b1; cyc(1); end
    inhibit_n = 1'b0; cyc(5);
    req = "R8"; inhibit_n = 1'b1; cyc(TWD + HOLD + 10);
    cyc(20); pulse(); cyc(10);
    req = "R1"; supply_ok = 1'b0; cyc(1); supply_ok = 1'b1; cyc(REL + 10);
    supply_ok = 1'b0; cyc(3); supply_ok = 1'b1; cyc(REL - 1); supply_ok = 1'b0; cyc(1);
    supply_ok = 1'b1; cyc(REL + 5);
    req = "R9"; rst = 1'b1; cyc(2); rst = 1'b0; cyc(REL + 40);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule